// File: doc/BRIEF.md
# Six-Pipe Receive Address Matcher

The block sits behind a packet receiver. It compares the 5-byte address of each incoming packet with the addresses of six receive pipes and reports whether a pipe matched and which one. Pipes 0 and 1 each store a full 40-bit address. Pipes 2 to 5 store only their own low byte and share the upper 32 bits of pipe 1. A per-pipe enable mask decides which pipes may take part in the comparison.

Each packet that matches leaves its pipe number in a three-entry status queue, one entry per payload held downstream. The queue head shows the pipe of the oldest payload still held. A read-payload strobe removes that entry. Packet addresses arrive on a valid/ready stream. Ready falls while the queue is full, and an address offered without ready is neither compared nor stored. Configuration writes and the result outputs are plain pins.

Top module: `rx_pipe_matcher`

## Requirements
- R1: After reset the effective pipe addresses are E7E7E7E7E7 (pipe 0), C2C2C2C2C2 (pipe 1), C2C2C2C2C3, C2C2C2C2C4, C2C2C2C2C5 and C2C2C2C2C6 (pipes 2 to 5). The enable mask is 6'b000011, res_valid is 0 and head_pipe is 7.
- R2: With `cfg_sel` 0 or 1, a write stores all 40 bits of `cfg_wdata` as the address of that pipe. Pipes 0 and 1 compare against all 40 bits.
- R3: The effective address of pipe 2 to 5 is {pipe 1 address[39:8], own low byte}. Rewriting pipe 1 therefore changes the address that pipes 2 to 5 respond to.
- R4: A write with `cfg_sel` 2 to 5 stores only `cfg_wdata[7:0]`. Bits 39:8 of that write have no effect.
- R5: A pipe whose enable bit is 0 never matches. A write with `cfg_sel` 7 loads the mask from `cfg_wdata[5:0]`, where bit p enables pipe p.
- R6: When several enabled pipes match the same address, the lowest-numbered pipe is reported.
- R7: One cycle after a packet is accepted (`pkt_valid` and `pkt_ready` both high at a clock edge), res_valid is 1 for exactly one cycle. res_match then says whether a pipe matched, and res_pipe gives the pipe number, or 7 on a miss. With no accept, res_valid is 0.
- R8: Each accepted packet that matches appends its pipe number to a 3-entry first-in first-out queue. head_pipe shows the oldest entry, or 7 when the queue is empty. A packet that misses is accepted and dropped.
- R9: A `rd_pop` pulse removes the oldest entry. A pop on an empty queue changes nothing.
- R10: `pkt_ready` is 0 exactly while the queue holds 3 entries. A pop in the same cycle does not raise it.
- R11: A write with `cfg_sel` 6 changes no address and no enable bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Write target: 0-5 pipe address, 7 enable mask |
| cfg_wdata | input | 40 | Write data |
| pkt_valid | input | 1 | Packet address offered |
| pkt_ready | output | 1 | Matcher can accept an address |
| pkt_addr | input | 40 | Incoming packet address |
| res_valid | output | 1 | Result strobe, one cycle after accept |
| res_match | output | 1 | Some enabled pipe matched |
| res_pipe | output | 3 | Matched pipe, 7 on miss |
| rd_pop | input | 1 | Read-payload strobe, pops the queue head |
| head_pipe | output | 3 | Pipe of oldest held payload, 7 when empty |

## Verification
Every result has one register between stimulus and output. The match result appears on res_* the cycle after the accepting edge. The queue head reflects a push or pop made at that same edge, and a configuration write takes effect for packets offered from the next edge on. The bench changes inputs on the falling edge and samples at the following falling edge, so exactly one rising edge separates stimulus and check. pkt_ready depends only on stored state, so it is sampled just before that edge. Expected values come from a bench-side model of the addresses, the mask and the queue, stepped once per edge.

// File: rtl/rxm_pkg.sv
package rxm_pkg;
  localparam int NUM_PIPES  = 6;
  localparam int FULL_PIPES = 2;
  localparam int ADDR_BYTES = 5;
  localparam int ADDR_W     = ADDR_BYTES * 8;
  localparam int PIPE_W     = $clog2(NUM_PIPES + 1);
  localparam int SEL_W      = 3;
  localparam int ENABLE_SEL = 7;
  localparam int Q_DEPTH    = 3;
  localparam int EN_RESET   = 3;
endpackage

// File: rtl/rxm_addr_regs.sv
module rxm_addr_regs #(
  parameter int NUM_PIPES  = rxm_pkg::NUM_PIPES,
  parameter int FULL_PIPES = rxm_pkg::FULL_PIPES,
  parameter int ADDR_BYTES = rxm_pkg::ADDR_BYTES,
  parameter int SEL_W      = rxm_pkg::SEL_W,
  parameter int ENABLE_SEL = rxm_pkg::ENABLE_SEL,
  parameter int EN_RESET   = rxm_pkg::EN_RESET
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic                                   cfg_we,
  input  logic [SEL_W-1:0]                       cfg_sel,
  input  logic [ADDR_BYTES*8-1:0]                cfg_wdata,
  output logic [NUM_PIPES-1:0][ADDR_BYTES*8-1:0] eff_addr,
  output logic [NUM_PIPES-1:0]                   en_mask
);
  localparam int ADDR_W    = ADDR_BYTES * 8;
  localparam int LOW_PIPES = NUM_PIPES - FULL_PIPES;

  logic [ADDR_W-1:0] full_q [FULL_PIPES];
  logic [7:0]        low_q  [LOW_PIPES];

  // pipe 0 repeats E7; pipe p>0 repeats C2 with low byte C1+p
  function automatic logic [7:0] dflt_low(int p);
    return (p == 0) ? 8'hE7 : 8'(8'hC1 + p);
  endfunction

  function automatic logic [ADDR_W-1:0] dflt_full(int p);
    return (p == 0) ? {ADDR_BYTES{8'hE7}}
                    : {{(ADDR_BYTES-1){8'hC2}}, dflt_low(p)};
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < FULL_PIPES; i++) full_q[i] <= dflt_full(i);
      for (int j = 0; j < LOW_PIPES; j++)  low_q[j]  <= dflt_low(j + FULL_PIPES);
      en_mask <= NUM_PIPES'(EN_RESET);
    end else if (cfg_we) begin
      if (cfg_sel == SEL_W'(ENABLE_SEL)) en_mask <= cfg_wdata[NUM_PIPES-1:0];
      for (int i = 0; i < FULL_PIPES; i++)
        if (cfg_sel == SEL_W'(i)) full_q[i] <= cfg_wdata;
      for (int j = 0; j < LOW_PIPES; j++)
        if (cfg_sel == SEL_W'(j + FULL_PIPES)) low_q[j] <= cfg_wdata[7:0];
    end
  end

  for (genvar p = 0; p < NUM_PIPES; p++) begin : g_eff
    if (p < FULL_PIPES) begin : g_full
      assign eff_addr[p] = full_q[p];
    end else begin : g_low
      assign eff_addr[p] = {full_q[FULL_PIPES-1][ADDR_W-1:8], low_q[p-FULL_PIPES]};
    end
  end
endmodule

// File: rtl/rxm_match.sv
module rxm_match #(
  parameter int NUM_PIPES  = rxm_pkg::NUM_PIPES,
  parameter int ADDR_BYTES = rxm_pkg::ADDR_BYTES,
  parameter int PIPE_W     = rxm_pkg::PIPE_W
) (
  input  logic [NUM_PIPES-1:0][ADDR_BYTES*8-1:0] eff_addr,
  input  logic [NUM_PIPES-1:0]                   en_mask,
  input  logic [ADDR_BYTES*8-1:0]                pkt_addr,
  output logic                                   hit,
  output logic [PIPE_W-1:0]                      hit_pipe
);
  logic [NUM_PIPES-1:0] eq_vec;

  for (genvar p = 0; p < NUM_PIPES; p++) begin : g_cmp
    assign eq_vec[p] = en_mask[p] && (eff_addr[p] == pkt_addr);
  end

  // scan high to low so the lowest index is the last to win
  always_comb begin
    hit      = 1'b0;
    hit_pipe = '1;
    for (int p = NUM_PIPES - 1; p >= 0; p--) begin
      if (eq_vec[p]) begin
        hit      = 1'b1;
        hit_pipe = PIPE_W'(p);
      end
    end
  end
endmodule

// File: rtl/rxm_status_q.sv
module rxm_status_q #(
  parameter int DEPTH  = rxm_pkg::Q_DEPTH,
  parameter int PIPE_W = rxm_pkg::PIPE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [PIPE_W-1:0] push_pipe,
  input  logic              pop,
  output logic [PIPE_W-1:0] head,
  output logic              full
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [PIPE_W-1:0] slot [DEPTH];
  logic [CNT_W-1:0]  count;
  logic              do_pop, do_push;
  logic [CNT_W-1:0]  wr_idx;

  assign full    = (count == CNT_W'(DEPTH));
  assign do_pop  = pop && (count != '0);
  assign do_push = push && !full;
  assign wr_idx  = do_pop ? count - 1'b1 : count;
  assign head    = (count == '0) ? '1 : slot[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count <= '0;
      for (int i = 0; i < DEPTH; i++) slot[i] <= '1;
    end else begin
      if (do_pop)
        for (int i = 0; i < DEPTH - 1; i++) slot[i] <= slot[i+1];
      if (do_push) slot[wr_idx] <= push_pipe;
      count <= count + CNT_W'(do_push) - CNT_W'(do_pop);
    end
  end
endmodule

// File: rtl/rx_pipe_matcher.sv
module rx_pipe_matcher (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic [2:0]  cfg_sel,
  input  logic [39:0] cfg_wdata,
  input  logic        pkt_valid,
  output logic        pkt_ready,
  input  logic [39:0] pkt_addr,
  output logic        res_valid,
  output logic        res_match,
  output logic [2:0]  res_pipe,
  input  logic        rd_pop,
  output logic [2:0]  head_pipe
);
  import rxm_pkg::*;

  logic [NUM_PIPES-1:0][ADDR_W-1:0] eff_addr;
  logic [NUM_PIPES-1:0]             en_mask;
  logic                             hit;
  logic [PIPE_W-1:0]                hit_pipe;
  logic                             q_full;
  logic                             accept;

  assign pkt_ready = !q_full;
  assign accept    = pkt_valid && pkt_ready;

  rxm_addr_regs u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .eff_addr(eff_addr), .en_mask(en_mask)
  );

  rxm_match u_match (
    .eff_addr(eff_addr), .en_mask(en_mask), .pkt_addr(pkt_addr),
    .hit(hit), .hit_pipe(hit_pipe)
  );

  rxm_status_q u_q (
    .clk(clk), .rst_n(rst_n), .push(accept && hit), .push_pipe(hit_pipe),
    .pop(rd_pop), .head(head_pipe), .full(q_full)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_match <= 1'b0;
      res_pipe  <= '1;
    end else begin
      res_valid <= accept;
      if (accept) begin
        res_match <= hit;
        res_pipe  <= hit_pipe;
      end
    end
  end
endmodule

// File: rtl/rx_pipe_matcher_chk.sv
module rx_pipe_matcher_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       pkt_valid,
  input logic       pkt_ready,
  input logic       res_valid,
  input logic       res_match,
  input logic [2:0] res_pipe,
  input logic       rd_pop,
  input logic [2:0] head_pipe,
  input logic [5:0] en_mask
);
  logic [5:0] en_d;
  always_ff @(posedge clk) en_d <= en_mask;

  a_r7_result_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_valid && pkt_ready) |=> res_valid);

  a_r7_no_result_without_accept: assert property (@(posedge clk) disable iff (!rst_n)
    !(pkt_valid && pkt_ready) |=> !res_valid);

  a_r7_miss_code: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_match) |-> (res_pipe == 3'd7));

  a_r5_match_only_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_match) |-> (res_pipe < 3'd6 && en_d[res_pipe]));

  a_r10_empty_is_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (head_pipe == 3'd7) |-> pkt_ready);

  a_r9_pop_empty_stays_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (head_pipe == 3'd7 && !(pkt_valid && pkt_ready)) |=> (head_pipe == 3'd7));

  a_r8_head_holds_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!(pkt_valid && pkt_ready) && !rd_pop) |=> $stable(head_pipe));
endmodule

bind rx_pipe_matcher rx_pipe_matcher_chk chk_i (
  .clk(clk), .rst_n(rst_n), .pkt_valid(pkt_valid), .pkt_ready(pkt_ready),
  .res_valid(res_valid), .res_match(res_match), .res_pipe(res_pipe),
  .rd_pop(rd_pop), .head_pipe(head_pipe), .en_mask(en_mask)
);

// File: tb/rx_pipe_matcher_tb_top.sv
`timescale 1ns/1ps
module rx_pipe_matcher_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_sel = '0;
  logic [39:0] cfg_wdata = '0;
  logic        pkt_valid = 1'b0;
  logic        pkt_ready;
  logic [39:0] pkt_addr = '0;
  logic        res_valid, res_match;
  logic [2:0]  res_pipe, head_pipe;
  logic        rd_pop = 1'b0;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  rx_pipe_matcher dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .pkt_valid(pkt_valid), .pkt_ready(pkt_ready),
    .pkt_addr(pkt_addr), .res_valid(res_valid), .res_match(res_match),
    .res_pipe(res_pipe), .rd_pop(rd_pop), .head_pipe(head_pipe)
  );

  // reference model
  logic [39:0] m_full [2];
  logic [7:0]  m_low  [4];
  logic [5:0]  m_en;
  int          m_q [3];
  int          m_cnt;

  function automatic logic [39:0] m_eff(int p);
    return (p < 2) ? m_full[p] : {m_full[1][39:8], m_low[p-2]};
  endfunction

  function automatic int m_pick(logic [39:0] a);
    for (int p = 0; p < 6; p++) if (m_en[p] && m_eff(p) == a) return p;
    return 7;
  endfunction

  function automatic int m_head();
    return (m_cnt == 0) ? 7 : m_q[0];
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cfg(int sel, logic [39:0] d);
    cfg_we = 1'b1; cfg_sel = 3'(sel); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    if (sel < 2) m_full[sel] = d;
    else if (sel < 6) m_low[sel-2] = d[7:0];
    else if (sel == 7) m_en = d[5:0];
  endtask

  task automatic step(bit v, logic [39:0] a, bit pop, string tag);
    bit acc;
    int pk;
    pkt_valid = v; pkt_addr = a; rd_pop = pop;
    #0.5;
    chk(pkt_ready == (m_cnt < 3), "R10 ready", pkt_ready, m_cnt < 3);
    acc = v && (m_cnt < 3);
    pk  = m_pick(a);
    @(negedge clk);
    pkt_valid = 1'b0; rd_pop = 1'b0;
    if (pop && m_cnt > 0) begin
      m_q[0] = m_q[1]; m_q[1] = m_q[2]; m_cnt--;
    end
    if (acc && pk != 7) begin
      m_q[m_cnt] = pk; m_cnt++;
    end
    chk(res_valid == acc, {tag, " R7 res_valid"}, res_valid, acc);
    if (acc) begin
      chk(res_match == (pk != 7), {tag, " res_match"}, res_match, pk != 7);
      chk(res_pipe == 3'(pk), {tag, " res_pipe"}, res_pipe, pk);
    end
    chk(head_pipe == 3'(m_head()), {tag, " R8 head_pipe"}, head_pipe, m_head());
  endtask

  initial begin
    m_full[0] = 40'hE7E7E7E7E7;
    m_full[1] = 40'hC2C2C2C2C2;
    for (int j = 0; j < 4; j++) m_low[j] = 8'(8'hC3 + j);
    m_en = 6'h03;
    m_cnt = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk(head_pipe == 3'd7, "R1 head", head_pipe, 7);
    chk(res_valid == 1'b0, "R1 res_valid", res_valid, 0);
    chk(pkt_ready == 1'b1, "R1 ready", pkt_ready, 1);
    // R1 default addresses with reset mask, pipe 2 disabled (R5)
    step(1, 40'hE7E7E7E7E7, 1, "R1 pipe0");
    step(1, 40'hC2C2C2C2C2, 1, "R1 pipe1");
    step(1, 40'hC2C2C2C2C3, 1, "R5 reset-disabled");
    step(0, 40'h0, 1, "R9 drain");
    // R5 sweep every mask over defaults and a miss
    for (int mask = 0; mask < 64; mask++) begin
      cfg(7, 40'(mask));
      for (int k = 0; k < 7; k++)
        step(1, (k < 6) ? m_eff(k) : 40'h0123456789, (k % 2) == 0, "R5 sweep");
    end
    for (int k = 0; k < 4; k++) step(0, 40'h0, 1, "R9 drain");
    cfg(7, 40'h3F);
    // R2 full-width compare on pipe 0 and 1
    cfg(0, 40'hA55A0F1E2D);
    step(1, 40'hA55A0F1E2D, 1, "R2 pipe0 new");
    step(1, 40'hA55A0F1E2C, 1, "R2 one-bit miss");
    step(1, 40'hE7E7E7E7E7, 1, "R2 old pipe0");
    // R3 pipes 2-5 follow pipe 1 upper bytes
    cfg(1, 40'h1122334455);
    for (int k = 0; k < 6; k++) step(1, m_eff(k), 1, "R3 shared upper");
    step(1, 40'hC2C2C2C2C4, 1, "R3 old upper");
    // R4 upper bits of a low-pipe write are dropped
    cfg(2, 40'hFFFFFFFF99);
    step(1, 40'h1122334499, 1, "R4 low byte only");
    step(1, 40'hFFFFFFFF99, 1, "R4 upper ignored");
    // R6 priority: pipe 0 equals pipe 4
    cfg(0, 40'h11223344C5);
    step(1, 40'h11223344C5, 1, "R6 priority");
    cfg(7, 40'h3E);
    step(1, 40'h11223344C5, 1, "R6 next pipe");
    cfg(7, 40'h3F);
    // R8/R10 fill queue, oldest-first, then pops including on empty (R9)
    step(0, 40'h0, 1, "R9 drain");
    step(1, m_eff(3), 0, "R8 fill");
    step(1, m_eff(1), 0, "R8 fill");
    step(1, m_eff(5), 0, "R8 fill");
    step(1, m_eff(2), 0, "R10 full blocked");
    step(1, m_eff(2), 1, "R10 full with pop");
    step(1, m_eff(2), 0, "R8 refill");
    for (int k = 0; k < 5; k++) step(0, 40'h0, 1, "R9 pop");
    // R11 sel 6 write ignored
    cfg(6, 40'h0000000000);
    for (int k = 0; k < 6; k++) step(1, m_eff(k), 1, "R11 sel6 ignored");
    step(1, 40'h0, 1, "R11 miss");
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule